// File: doc/BRIEF.md
# Alignment-Aware Load/Store Access Unit

The unit sits between a processor load/store port and a byte-addressed memory that is 32 bits wide. It takes one request at a time: a byte address, an access size of 1, 2, 4 or 8 bytes, a direction, and up to 64 bits of store data. It turns the request into a run of word accesses. A mode input chooses between two behaviours. In strict mode a request whose address does not suit its size is refused with an error and never reaches memory. In tolerant mode any request is served: the unit issues every word the request touches, one per cycle in ascending order, and sets byte enables only on the lanes it covers.

On loads, the returned words are stored and then shifted, so the byte at the request address comes out in the least significant position. Bits above the access size read as zero. Completion is signalled by a single-cycle done pulse, which carries the load data, or the error flag for a refused request. The memory side has no stall: it takes one access per cycle and returns load data one cycle after the access.

Top module: `align_access_unit`

## Requirements
- R1: `size_i` encodes the access width as 0=1 byte, 1=2 bytes, 2=4 bytes, 3=8 bytes. A request is misaligned when any of its low address bits `addr[2:0]` under the mask (bytes-1) is set, so 1-byte requests are never misaligned.
- R2: With `strict_i`=1, a misaligned request raises `done_o` and `err_o` together in the cycle after acceptance and issues no memory access.
- R3: Any request that is not refused issues N word accesses on consecutive cycles, starting the cycle after acceptance. The addresses are floor(addr/4)*4, then +4 per access, wrapping within the address width. N = ((addr mod 4) + bytes - 1) div 4 + 1, so an 8-byte request takes 2 accesses at word offset 0 and 3 accesses otherwise.
- R4: Aligned requests in strict mode are served exactly as in tolerant mode.
- R5: For a load, `rdata_o` at the done pulse holds byte addr+i in bits [8i+7:8i] for every i below the access size, and zero above it.
- R6: Every access of a store has `mem_we_o`=1. Bit j of `mem_be_o` in access k is set exactly when byte position 4k+j lies in [addr mod 4, addr mod 4 + bytes). The enabled lane carries store byte (4k+j - addr mod 4).
- R7: For a served request, `done_o` pulses for one cycle, N+2 cycles after acceptance, with `err_o`=0.
- R8: `req_ready_o` is low from the cycle after acceptance through the done cycle, so no new request is taken while accesses are outstanding.
- R9: During reset, `req_ready_o`=1 and `mem_req_o`=0, `done_o`=0, `err_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Unit idle, request accepted when valid |
| req_we_i | input | 1 | 1 = store, 0 = load |
| req_size_i | input | 2 | Access width code |
| req_addr_i | input | AW | Byte address |
| req_wdata_i | input | 64 | Store data, right-justified |
| strict_i | input | 1 | 1 = refuse misaligned requests |
| done_o | output | 1 | Completion pulse |
| err_o | output | 1 | Request refused (with done_o) |
| rdata_o | output | 64 | Right-justified load data (with done_o) |
| mem_req_o | output | 1 | Word access strobe |
| mem_we_o | output | 1 | Word access is a write |
| mem_addr_o | output | AW | Word-aligned byte address |
| mem_be_o | output | 4 | Byte lane enables |
| mem_wdata_o | output | 32 | Write word |
| mem_rdata_i | input | 32 | Read word, one cycle after the access |

## Verification
A wrong beat counter or span mask is visible on the memory bus within one cycle of the bad access. It shows as a skipped or extra word address, a stray byte enable, or a done pulse that arrives early or late against the N+2 count. A capture slot written with the wrong word, or a wrong shift amount, corrupts `rdata_o` at the done pulse of that same load. Every store is read back straight away with the same size and address, so a bad write lane appears in the next transaction. The sweep covers all four sizes at every address of a small address space in both modes, including the wrap past the top word.

// File: rtl/align_pkg.sv
package align_pkg;
  localparam int WORD_BYTES = 4;
  localparam int MAX_BYTES  = 8;
  localparam int MAX_BEATS  = 3;
  localparam int SPAN_BYTES = MAX_BEATS * WORD_BYTES;
  localparam int WORD_W     = WORD_BYTES * 8;
  localparam int DATA_W     = MAX_BYTES * 8;
  localparam int SPAN_W     = SPAN_BYTES * 8;

  typedef enum logic [1:0] {
    SZ_B = 2'd0,
    SZ_H = 2'd1,
    SZ_W = 2'd2,
    SZ_D = 2'd3
  } acc_size_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ISSUE, ST_WAIT, ST_DONE, ST_ERR
  } unit_state_e;

  function automatic logic [3:0] size_bytes(acc_size_e s);
    return 4'd1 << s;
  endfunction
endpackage

// File: rtl/align_split.sv
module align_split
  import align_pkg::*;
(
  input  logic [2:0]            addr_lo_i,
  input  acc_size_e             size_i,
  output logic                  misaligned_o,
  output logic [1:0]            n_beats_o,
  output logic [SPAN_BYTES-1:0] span_be_o
);
  logic [3:0] nbytes;
  logic [2:0] amask;
  logic [3:0] last_pos;

  always_comb begin
    nbytes       = size_bytes(size_i);
    amask        = 3'(nbytes - 4'd1);
    misaligned_o = |(addr_lo_i & amask);
    last_pos     = {2'b00, addr_lo_i[1:0]} + nbytes - 4'd1;
    n_beats_o    = last_pos[3:2] + 2'd1;
    span_be_o    = ((SPAN_BYTES'(1) << nbytes) - SPAN_BYTES'(1)) << addr_lo_i[1:0];
  end
endmodule

// File: rtl/align_merge.sv
module align_merge
  import align_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_en_i,
  input  logic [1:0]        cap_idx_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic [1:0]        off_i,
  input  acc_size_e         size_i,
  output logic [DATA_W-1:0] data_o
);
  logic [SPAN_W-1:0] span_q;
  logic [SPAN_W-1:0] shifted;
  logic [DATA_W-1:0] keep;

  for (genvar g = 0; g < MAX_BEATS; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                           span_q[g*WORD_W +: WORD_W] <= '0;
      else if (cap_en_i && cap_idx_i == 2'(g)) span_q[g*WORD_W +: WORD_W] <= word_i;
    end
  end

  always_comb begin
    shifted = span_q >> {off_i, 3'b000};
    unique case (size_i)
      SZ_B:    keep = DATA_W'(64'hFF);
      SZ_H:    keep = DATA_W'(64'hFFFF);
      SZ_W:    keep = DATA_W'(64'hFFFF_FFFF);
      default: keep = '1;
    endcase
    data_o = shifted[DATA_W-1:0] & keep;
  end
endmodule

// File: rtl/align_access_unit.sv
module align_access_unit
  import align_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_we_i,
  input  logic [1:0]        req_size_i,
  input  logic [AW-1:0]     req_addr_i,
  input  logic [63:0]       req_wdata_i,
  input  logic              strict_i,
  output logic              done_o,
  output logic              err_o,
  output logic [63:0]       rdata_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic [3:0]        mem_be_o,
  output logic [31:0]       mem_wdata_o,
  input  logic [31:0]       mem_rdata_i
);
  localparam int WAW = AW - 2;

  unit_state_e           state_q;
  acc_size_e             size_q;
  logic                  we_q;
  logic [WAW-1:0]        wbase_q;
  logic [1:0]            off_q;
  logic [DATA_W-1:0]     wdata_q;
  logic [1:0]            beat_q, nbeat_q;
  logic [SPAN_BYTES-1:0] span_be_q;
  logic                  cap_en_q;
  logic [1:0]            cap_idx_q;

  logic                  mis;
  logic [1:0]            n_beats;
  logic [SPAN_BYTES-1:0] span_be;
  logic                  accept;
  logic [SPAN_W-1:0]     wd_span;
  logic [DATA_W-1:0]     merged;

  align_split u_split (
    .addr_lo_i   (req_addr_i[2:0]),
    .size_i      (acc_size_e'(req_size_i)),
    .misaligned_o(mis),
    .n_beats_o   (n_beats),
    .span_be_o   (span_be)
  );

  align_merge u_merge (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cap_en_i (cap_en_q),
    .cap_idx_i(cap_idx_q),
    .word_i   (mem_rdata_i),
    .off_i    (off_q),
    .size_i   (size_q),
    .data_o   (merged)
  );

  assign req_ready_o = (state_q == ST_IDLE);
  assign accept      = req_valid_i && req_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      size_q    <= SZ_B;
      we_q      <= 1'b0;
      wbase_q   <= '0;
      off_q     <= '0;
      wdata_q   <= '0;
      beat_q    <= '0;
      nbeat_q   <= 2'd1;
      span_be_q <= '0;
      cap_en_q  <= 1'b0;
      cap_idx_q <= '0;
    end else begin
      cap_en_q  <= (state_q == ST_ISSUE) && !we_q;
      cap_idx_q <= beat_q;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          size_q    <= acc_size_e'(req_size_i);
          we_q      <= req_we_i;
          wbase_q   <= req_addr_i[AW-1:2];
          off_q     <= req_addr_i[1:0];
          wdata_q   <= req_wdata_i;
          beat_q    <= '0;
          nbeat_q   <= n_beats;
          span_be_q <= span_be;
          state_q   <= (strict_i && mis) ? ST_ERR : ST_ISSUE;
        end
        ST_ISSUE: begin
          beat_q <= beat_q + 2'd1;
          if (beat_q == nbeat_q - 2'd1) state_q <= ST_WAIT;
        end
        ST_WAIT: state_q <= ST_DONE; // last read word lands in merge buffer
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    wd_span     = {{(SPAN_W-DATA_W){1'b0}}, wdata_q} << {off_q, 3'b000};
    mem_req_o   = (state_q == ST_ISSUE);
    mem_we_o    = mem_req_o && we_q;
    mem_addr_o  = {wbase_q + WAW'(beat_q), 2'b00};
    mem_be_o    = mem_req_o ? span_be_q[{beat_q, 2'b00} +: 4] : 4'b0;
    mem_wdata_o = wd_span[{beat_q, 5'b00000} +: WORD_W];
    done_o      = (state_q == ST_DONE) || (state_q == ST_ERR);
    err_o       = (state_q == ST_ERR);
    rdata_o     = (state_q == ST_DONE && !we_q) ? merged : '0;
  end

  assert_err_follows_accept_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(req_valid_i && req_ready_o));
  assert_err_no_access_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !mem_req_o && done_o);
  assert_addr_ascending_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && $past(mem_req_o) |-> mem_addr_o == $past(mem_addr_o) + AW'(4));
  assert_lanes_nonempty_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> mem_be_o != 4'b0);
  assert_done_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_busy_blocks_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o || done_o) |-> !req_ready_o);
endmodule

// File: tb/align_access_unit_tb.sv
module align_access_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_we = 1'b0, strict = 1'b0;
  logic [1:0]  req_size = '0;
  logic [AW-1:0] req_addr = '0;
  logic [63:0] req_wdata = '0;
  logic        req_ready, done, err, mem_req, mem_we;
  logic [63:0] rdata;
  logic [AW-1:0] mem_addr;
  logic [3:0]  mem_be;
  logic [31:0] mem_wdata, mem_rdata;

  logic [7:0] mem_b [256];
  logic [7:0] shadow [256];
  int n_tests = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  align_access_unit #(.AW(AW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_we_i(req_we),
    .req_size_i(req_size), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .strict_i(strict), .done_o(done), .err_o(err), .rdata_o(rdata),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_be_o(mem_be), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata)
  );

  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) begin
        for (int j = 0; j < 4; j++)
          if (mem_be[j]) mem_b[8'(mem_addr + 8'(j))] <= mem_wdata[8*j +: 8];
      end else begin
        for (int j = 0; j < 4; j++) mem_rdata[8*j +: 8] <= mem_b[8'(mem_addr + 8'(j))];
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic txn(input bit st, input bit we, input int sz, input int addr, input logic [63:0] wd);
    int nbytes, off, nexp, beats, done_cyc;
    bit mis, refuse;
    logic [63:0] exp_rd;
    nbytes = 1 << sz;
    off    = addr % 4;
    mis    = (addr % nbytes) != 0;              // R1
    refuse = st && mis;
    nexp   = (off + nbytes - 1) / 4 + 1;
    beats  = 0;
    done_cyc = 0;
    exp_rd = '0;
    for (int i = 0; i < nbytes; i++) exp_rd[8*i +: 8] = shadow[(addr + i) % 256];
    @(negedge clk);
    chk(req_ready == 1'b1, "R8 ready when idle", 64'(req_ready), 64'd1);
    req_valid = 1'b1; req_we = we; req_size = 2'(sz); req_addr = AW'(addr);
    req_wdata = wd; strict = st;
    for (int cyc = 1; cyc <= 12; cyc++) begin
      @(negedge clk);
      if (cyc == 1) req_valid = 1'b0;
      chk(req_ready == 1'b0, "R8 ready low while busy", 64'(req_ready), 64'd0);
      if (mem_req) begin
        logic [3:0]  ebe;
        logic [31:0] ewd;
        logic [7:0]  ea;
        ebe = '0; ewd = mem_wdata;
        for (int j = 0; j < 4; j++) begin
          int g;
          g = 4 * beats + j;
          if (g >= off && g < off + nbytes) begin
            ebe[j] = 1'b1;
            ewd[8*j +: 8] = wd[8*(g - off) +: 8];
          end
        end
        ea = 8'((addr / 4) * 4 + 4 * beats);
        chk(!refuse, "R2 no access on refusal", 64'(mem_req), 64'd0);
        chk(mem_addr == ea && cyc == beats + 1, "R3 word address order",
            64'(mem_addr), 64'(ea));
        chk(mem_we == we, "R6 write strobe", 64'(mem_we), 64'(we));
        if (we) begin
          chk(mem_be == ebe, "R6 byte enables", 64'(mem_be), 64'(ebe));
          chk(mem_wdata == ewd, "R6 write lanes", 64'(mem_wdata), 64'(ewd));
        end
        beats++;
      end
      if (done) begin
        done_cyc = cyc;
        break;
      end
    end
    if (refuse) begin
      chk(done_cyc == 1 && err, "R2 refusal timing", 64'(done_cyc), 64'd1);
    end else begin
      chk(beats == nexp, st ? "R4 beat count strict" : "R3 beat count", 64'(beats), 64'(nexp));
      chk(done_cyc == nexp + 2 && !err, "R7 done timing", 64'(done_cyc), 64'(nexp + 2));
      if (!we) chk(rdata == exp_rd, "R5 load data", rdata, exp_rd);
      else for (int i = 0; i < nbytes; i++) shadow[(addr + i) % 256] = wd[8*i +: 8];
    end
    @(negedge clk);
    chk(!done, "R7 single done pulse", 64'(done), 64'd0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem_b[i]  = 8'(i * 7 + 3);
      shadow[i] = 8'(i * 7 + 3);
    end
    repeat (3) @(negedge clk);
    chk(req_ready && !mem_req && !done && !err, "R9 reset state",
        {60'd0, req_ready, mem_req, done, err}, 64'h8);
    rst_n = 1'b1;
    for (int st = 0; st < 2; st++)
      for (int sz = 0; sz < 4; sz++)
        for (int a = 0; a < 256; a++) begin
          txn(st[0], 1'b1, sz, a, {$urandom, $urandom});
          txn(st[0], 1'b0, sz, a, 64'd0);
        end
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule